// File: doc/BRIEF.md
# Half-Warp Bank Conflict Scheduler

This block takes one shared-memory access from a group of 16 lanes. Each lane brings an active bit and a 32-bit word address. The storage is split into 16 banks. Each bank can deliver one word per cycle, and the bank a word lives in is set by the low four bits of its word address. The block turns the access into a sequence of service cycles. In each cycle every bank serves at most one distinct word, and lanes that ask for the same word are served together in that cycle as a broadcast.

When a request is accepted, the block stores the lane addresses and computes how many cycles the access will take. That number is the largest count of distinct words that fall into any one bank. The block then steps through the cycles. In each cycle it gives, for every bank, a valid bit, the word to fetch and the mask of lanes that receive it. `busy` is high while the cycles run, and `outLast` marks the final cycle. A request with no active lane takes no service cycles and only raises `done`. Only one request is scheduled at a time, so conflicts between separate groups of lanes never arise.

Top module: `bank_sched`

## Requirements
- R1: A lane is only ever served by bank `addr[3:0]`, so bank b's word always has low four bits equal to b.
- R2: In each service cycle a bank serves at most one distinct word, and every lane in its mask requested exactly that word.
- R3: An access whose active lanes all fall in different banks completes in one service cycle.
- R4: An access where every active lane reads the same word completes in one service cycle, with all of those lanes in that bank's mask.
- R5: The number of service cycles, also reported on `cycleCount` from the first service cycle on, equals the largest number of distinct words requested in any single bank. A word stride of 2 across 16 lanes gives 2 cycles, and a stride of 8 gives 8 cycles.
- R6: All active lanes that request the same word are served in the same cycle.
- R7: Within a bank, distinct words are served in increasing order of the lowest lane index that requests each one.
- R8: `reqReady` is high only while idle. `busy` is high from the cycle after acceptance through the final service cycle, `outLast` is high on that final cycle only, and `done` pulses for one cycle right after it. A `reqValid` raised while busy is ignored, together with its lanes.
- R9: A request with no active lanes is accepted, never raises `busy`, and pulses `done` in the cycle after acceptance.
- R10: Inactive lanes never appear in any mask, and every active lane is served exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqActive | input | 16 | Active bit per lane |
| reqAddr | input | 512 | Word address per lane; lane i at bits [32i+31:32i] |
| busy | output | 1 | Service cycles in progress |
| outLast | output | 1 | Current service cycle is the final one |
| outBankValid | output | 16 | Bank b serves a word this cycle |
| outBankAddr | output | 512 | Word served by bank b at bits [32b+31:32b] |
| outBankMask | output | 256 | Lanes served by bank b at bits [16b+15:16b] |
| cycleCount | output | 5 | Total service cycles of the current request |
| done | output | 1 | One-cycle pulse after a request finishes |

## Verification
A request is accepted on the rising edge where `reqValid` and `reqReady` are both high. The first service cycle appears on the outputs right after that edge, and `cycleCount` is valid from then on. Each later service cycle follows one edge after the previous one. `busy` falls and `done` pulses one edge after the cycle flagged `outLast`. For an empty request, `done` shows one edge after acceptance. The bench drives inputs and samples outputs on falling edges, counting edges from acceptance. It builds the expected per-bank word lists and lane masks from the lane addresses, ordered by first requesting lane, so every service cycle is compared with the cycle in which it is due.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new request
    logic step;  // retire the lanes served this cycle
  } schedStrobe_t;
endpackage

// File: rtl/bank_sched_dp.sv
module bank_sched_dp
  import bank_sched_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  schedStrobe_t               strobe,
  input  logic [LANES-1:0]           reqActive,
  input  logic [LANES*ADDR_W-1:0]    reqAddr,
  output logic [BANKS-1:0]           bankValid,
  output logic [BANKS*ADDR_W-1:0]    bankAddr,
  output logic [BANKS*LANES-1:0]     bankMask,
  output logic                       lastNow,
  output logic                       anyActive,
  output logic [$clog2(LANES+1)-1:0] cycleCount
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W  = $clog2(LANES + 1);

  logic [ADDR_W-1:0] addrQ [LANES];
  logic [LANES-1:0]  pendQ;
  logic [CNT_W-1:0]  cycleCountQ;
  logic [LANES-1:0]  servedAll;
  logic [LANES-1:0]  maskOf [BANKS];
  logic [CNT_W-1:0]  maxDistinct;

  // Per-bank selection of the word owned by the lowest pending lane
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              leadValid;
    logic [LANE_W-1:0] leadIdx;
    logic [ADDR_W-1:0] leadWord;

    always_comb begin
      leadValid = 1'b0;
      leadIdx   = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pendQ[l] && addrQ[l][BANK_W-1:0] == BANK_W'(b)) begin
          leadValid = 1'b1;
          leadIdx   = LANE_W'(l);
        end
      end
      leadWord = addrQ[leadIdx];
      for (int l = 0; l < LANES; l++) begin
        maskOf[b][l] = leadValid && pendQ[l] && (addrQ[l] == leadWord);
      end
    end

    assign bankValid[b]                    = leadValid;
    assign bankAddr[b*ADDR_W +: ADDR_W]    = leadValid ? leadWord : '0;
    assign bankMask[b*LANES +: LANES]      = maskOf[b];
  end

  always_comb begin
    servedAll = '0;
    for (int b = 0; b < BANKS; b++) servedAll = servedAll | maskOf[b];
  end

  assign lastNow   = (pendQ & ~servedAll) == '0;
  assign anyActive = |reqActive;

  // Number of distinct words per bank in the incoming request; keep the largest
  always_comb begin
    logic [LANES-1:0] firstReq;
    logic [CNT_W-1:0] perBank;
    firstReq = '0;
    for (int l = 0; l < LANES; l++) begin
      firstReq[l] = reqActive[l];
      for (int j = 0; j < l; j++) begin
        if (reqActive[j] && reqAddr[j*ADDR_W +: ADDR_W] == reqAddr[l*ADDR_W +: ADDR_W])
          firstReq[l] = 1'b0;
      end
    end
    maxDistinct = '0;
    for (int b = 0; b < BANKS; b++) begin
      perBank = '0;
      for (int l = 0; l < LANES; l++) begin
        if (firstReq[l] && reqAddr[l*ADDR_W +: BANK_W] == BANK_W'(b))
          perBank = perBank + 1'b1;
      end
      if (perBank > maxDistinct) maxDistinct = perBank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ       <= '0;
      cycleCountQ <= '0;
      for (int l = 0; l < LANES; l++) addrQ[l] <= '0;
    end else if (strobe.load) begin
      pendQ       <= reqActive;
      cycleCountQ <= maxDistinct;
      for (int l = 0; l < LANES; l++) addrQ[l] <= reqAddr[l*ADDR_W +: ADDR_W];
    end else if (strobe.step) begin
      pendQ <= pendQ & ~servedAll;
    end
  end

  assign cycleCount = cycleCountQ;

  // A step must always retire at least one lane (R10: each lane served once, no stall)
  p_progress_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> servedAll != '0);

  // Lanes retired by a step are gone from the pending set afterwards (R10)
  p_retire_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !strobe.load |=> (pendQ & $past(servedAll)) == '0);
endmodule

// File: rtl/bank_sched_ctrl.sv
module bank_sched_ctrl
  import bank_sched_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       anyActive,
  input  logic                       lastNow,
  input  logic [$clog2(LANES+1)-1:0] cycleCount,
  output schedStrobe_t               strobe,
  output logic                       reqReady,
  output logic                       busy,
  output logic                       done
);
  localparam int CNT_W = $clog2(LANES + 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t stateQ;
  logic   doneQ;
  logic [CNT_W-1:0] stepCnt;

  assign reqReady    = (stateQ == S_IDLE);
  assign busy        = (stateQ == S_RUN);
  assign strobe.load = reqReady && reqValid;
  assign strobe.step = busy;
  assign done        = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      doneQ   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.load) begin
        stepCnt <= '0;
        if (anyActive) stateQ <= S_RUN;
        else           doneQ  <= 1'b1;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
        if (lastNow) begin
          stateQ <= S_IDLE;
          doneQ  <= 1'b1;
        end
      end
    end
  end

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastNow |=> busy);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && lastNow |=> !busy && done);

  p_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && reqValid && !anyActive |=> done && !busy);

  p_cycles_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy && lastNow |-> (stepCnt + 1'b1) == cycleCount);
endmodule

// File: rtl/bank_sched.sv
module bank_sched
  import bank_sched_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [LANES-1:0]           reqActive,
  input  logic [LANES*ADDR_W-1:0]    reqAddr,
  output logic                       busy,
  output logic                       outLast,
  output logic [BANKS-1:0]           outBankValid,
  output logic [BANKS*ADDR_W-1:0]    outBankAddr,
  output logic [BANKS*LANES-1:0]     outBankMask,
  output logic [$clog2(LANES+1)-1:0] cycleCount,
  output logic                       done
);
  schedStrobe_t strobe;
  logic lastNow;
  logic anyActive;

  bank_sched_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .anyActive(anyActive),
    .lastNow(lastNow), .cycleCount(cycleCount), .strobe(strobe),
    .reqReady(reqReady), .busy(busy), .done(done)
  );

  bank_sched_dp #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqActive(reqActive),
    .reqAddr(reqAddr), .bankValid(outBankValid), .bankAddr(outBankAddr),
    .bankMask(outBankMask), .lastNow(lastNow), .anyActive(anyActive),
    .cycleCount(cycleCount)
  );

  assign outLast = busy && lastNow;
endmodule

// File: tb/bank_sched_tb.sv
module bank_sched_tb;
  localparam int L = 16;
  localparam int B = 16;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [L-1:0] reqActive = '0;
  logic [L*W-1:0] reqAddr = '0;
  logic busy, outLast, done;
  logic [B-1:0] outBankValid;
  logic [B*W-1:0] outBankAddr;
  logic [B*L-1:0] outBankMask;
  logic [4:0] cycleCount;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int obsCycles = 0;
  bit finished = 0;

  logic [W-1:0] tAddr [L];
  logic [L-1:0] tAct;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  bank_sched u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqActive(reqActive), .reqAddr(reqAddr), .busy(busy), .outLast(outLast),
    .outBankValid(outBankValid), .outBankAddr(outBankAddr),
    .outBankMask(outBankMask), .cycleCount(cycleCount), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // Issue tAct/tAddr and compare every service cycle with a model built from the requirements
  task automatic runReq(input bit noise);
    logic [W-1:0] wl [B][L];
    int nW [B];
    int maxN;
    bit dup;
    maxN = 0;
    for (int b = 0; b < B; b++) begin
      nW[b] = 0;
      for (int l = 0; l < L; l++) begin
        if (tAct[l] && tAddr[l][3:0] == 4'(b)) begin
          dup = 0;
          for (int j = 0; j < l; j++)
            if (tAct[j] && tAddr[j] == tAddr[l]) dup = 1;
          if (!dup) begin
            wl[b][nW[b]] = tAddr[l];
            nW[b]++;
          end
        end
      end
      if (nW[b] > maxN) maxN = nW[b];
    end

    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready while idle", 64'(reqReady), 64'd1);
    reqActive = tAct;
    for (int l = 0; l < L; l++) reqAddr[l*W +: W] = tAddr[l];
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    obsCycles = 0;

    if (maxN == 0) begin
      check(done == 1'b1 && busy == 1'b0, "R9", "empty request done/busy",
            64'({done, busy}), 64'b10);
      return;
    end

    for (int k = 0; k < maxN; k++) begin
      logic [B-1:0] expV;
      bit okA;
      bit okM;
      int badB;
      expV = '0;
      okA = 1;
      okM = 1;
      badB = -1;
      for (int b = 0; b < B; b++) begin
        logic [L-1:0] em;
        expV[b] = (k < nW[b]);
        em = '0;
        if (expV[b]) begin
          for (int l = 0; l < L; l++) em[l] = tAct[l] && tAddr[l] == wl[b][k];
          if (outBankAddr[b*W +: W] != wl[b][k]) begin okA = 0; badB = b; end
        end
        if (outBankMask[b*L +: L] != em) begin okM = 0; badB = b; end
      end
      if (busy) obsCycles++;
      check(busy == 1'b1 && reqReady == 1'b0, "R8", "busy during service",
            64'({busy, reqReady}), 64'b10);
      check(outLast == (k == maxN - 1), "R8", "last flag", 64'(outLast), 64'(k == maxN - 1));
      check(outBankValid == expV, "R1", "bank valid set", 64'(outBankValid), 64'(expV));
      check(okA, "R7", $sformatf("word order bank %0d cycle %0d", badB, k),
            (badB >= 0) ? 64'(outBankAddr[badB*W +: W]) : 64'd0, 64'd0);
      check(okM, "R6", $sformatf("lane mask bank %0d cycle %0d (R2/R10)", badB, k),
            (badB >= 0) ? 64'(outBankMask[badB*L +: L]) : 64'd0, 64'd0);
      if (k == 0)
        check(cycleCount == 5'(maxN), "R5", "reported cycle count", 64'(cycleCount), 64'(maxN));
      if (noise && k < maxN - 1) begin
        reqValid = 1'b1;
        reqActive = 16'hFFFF;
        for (int l = 0; l < L; l++) reqAddr[l*W +: W] = nextRand();
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    check(busy == 1'b0 && done == 1'b1 && reqReady == 1'b1, "R8", "finish handshake",
          64'({busy, done, reqReady}), 64'b011);
  endtask

  task automatic strideReq(input int base, input int stride, input bit noise);
    tAct = 16'hFFFF;
    for (int l = 0; l < L; l++) tAddr[l] = 32'(base + l * stride);
    runReq(noise);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && reqReady == 1 && done == 0 && outBankValid == 0 && outLast == 0,
          "R8", "reset state", 64'({busy, reqReady, done, outLast}), 64'b0100);

    // Stride sweep, every lane active
    for (int s = 0; s <= 17; s++) begin
      strideReq(0, s, 1'b0);
      if (s == 0) check(obsCycles == 1, "R4", "broadcast in one cycle", 64'(obsCycles), 64'd1);
      if (s == 1) check(obsCycles == 1, "R3", "conflict-free in one cycle", 64'(obsCycles), 64'd1);
      if (s == 2) check(obsCycles == 2, "R5", "stride 2 two cycles", 64'(obsCycles), 64'd2);
      if (s == 8) check(obsCycles == 8, "R5", "stride 8 eight cycles", 64'(obsCycles), 64'd8);
      if (s == 16) check(obsCycles == 16, "R5", "stride 16 sixteen cycles", 64'(obsCycles), 64'd16);
    end
    strideReq(7, 1, 1'b1);
    check(obsCycles == 1, "R3", "offset unit stride", 64'(obsCycles), 64'd1);
    strideReq(5, 3, 1'b1);
    strideReq(1234, 0, 1'b1);
    check(obsCycles == 1, "R4", "offset broadcast", 64'(obsCycles), 64'd1);

    // Partial masks: inactive lanes must not be served or counted
    tAct = 16'h5555;
    for (int l = 0; l < L; l++) tAddr[l] = 32'(l * 2);
    runReq(1'b0);
    check(obsCycles == 2, "R10", "even lanes stride 2", 64'(obsCycles), 64'd2);
    tAct = 16'h8001;
    for (int l = 0; l < L; l++) tAddr[l] = 32'(l * 16);
    runReq(1'b0);
    check(obsCycles == 2, "R10", "two lanes in one bank", 64'(obsCycles), 64'd2);

    // Empty request
    tAct = '0;
    for (int l = 0; l < L; l++) tAddr[l] = 32'(l * 16);
    runReq(1'b0);
    @(negedge clk);
    check(busy == 0 && done == 0, "R9", "empty request leaves no service", 64'({busy, done}), 64'b00);

    // Merge and order: bank 0 words 48,16,0 by first lane; lanes 2 and 4 join earlier lanes
    tAct = 16'h001F;
    tAddr[0] = 48; tAddr[1] = 16; tAddr[2] = 48; tAddr[3] = 0; tAddr[4] = 16;
    for (int l = 5; l < L; l++) tAddr[l] = 32'(l);
    runReq(1'b0);
    check(obsCycles == 3, "R7", "three ordered words", 64'(obsCycles), 64'd3);

    // Pseudo-random accesses over a small window to force merges and conflicts
    for (int t = 0; t < 80; t++) begin
      tAct = 16'(nextRand());
      if (t % 5 == 0) tAct = 16'hFFFF;
      for (int l = 0; l < L; l++) tAddr[l] = 32'(nextRand() % 48);
      runReq(t[0]);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule